// File: doc/BRIEF.md
# Incremental Code Phase Stepper

This block produces the chip-rate timing for a sliding-correlator receiver and lets the receiver move its local spreading-code phase in single, controlled steps. A reference clock running at RATIO_K times the chip rate (K between 4 and 16) feeds a down-counting divider. That divider normally produces one chip-enable pulse every K reference cycles. A chip counter running over CODE_LEN chips marks the end of each code period with an epoch strobe. The local code generator and the correlator sit outside this block and advance on these two pulses.

A phase step is made by changing the length of exactly one chip period. An advance request shortens it to K-1 reference cycles. A retard request stretches it to K+1. Either way the phase moves by one reference cycle. The step is applied to the chip period that follows the one in which it was accepted. At most one step is accepted per code epoch. A later request in the same epoch is discarded and raises a sticky overflow flag until the epoch ends.

For acquisition, a search mode inserts one retard step at every epoch boundary, so the receiver dwells one full epoch at each trial phase. It keeps doing so until the lock input goes high. From then on, manual tracking requests control the phase.

Top module: `ipm_phase_stepper`

## Requirements
- R1: With no accepted step, chip_en is a one-cycle pulse every RATIO_K clock cycles.
- R2: An accepted advance request (adv_req high, ret_req low, for one cycle) makes the next chip period after the current one exactly RATIO_K-1 cycles. All later periods return to RATIO_K.
- R3: An accepted retard request (ret_req high, adv_req low) makes the next chip period after the current one exactly RATIO_K+1 cycles. All later periods return to RATIO_K.
- R4: chip_idx counts chip_en pulses from 0 to CODE_LEN-1 and then wraps to 0. epoch_stb is high together with the chip_en pulse on which chip_idx equals CODE_LEN-1, so an epoch is CODE_LEN chips.
- R5: Only the first step request in an epoch is accepted. Any later request in that epoch leaves the chip periods unchanged and sets overflow. overflow stays high until the epoch's strobe and is low on the cycle after it. A request sampled in the epoch_stb cycle belongs to the new epoch.
- R6: adv_req and ret_req high in the same cycle produce no step and no overflow, and do not use up the epoch's single step.
- R7: While sweep_en is high and lock_in is low, one retard step is accepted at every epoch strobe, which stretches chip 1 of the next epoch to RATIO_K+1 cycles. Manual requests have no effect and set no overflow.
- R8: Once lock_in is high, automatic steps stop and manual advance and retard requests are honoured again.
- R9: During reset, chip_en, epoch_stb and overflow are low and chip_idx is 0. The divider restarts at a full RATIO_K period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, RATIO_K times the chip rate |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_req | input | 1 | Request to shorten one chip period by one clock |
| ret_req | input | 1 | Request to lengthen one chip period by one clock |
| sweep_en | input | 1 | Enables automatic per-epoch retard search |
| lock_in | input | 1 | Lock indication from the correlator; ends the search |
| chip_en | output | 1 | One-cycle pulse per chip |
| epoch_stb | output | 1 | One-cycle pulse on the last chip of each epoch |
| chip_idx | output | $clog2(CODE_LEN) | Index of the current chip within the epoch |
| overflow | output | 1 | Sticky flag: a step request was discarded in this epoch |

## Verification
The bench logs the length of every chip period and checks the exact sequence around each request. This exposes a design that applies a step to the wrong period, moves the phase by two clocks, or fails to return to K. It places a second request inside an epoch that already holds a step: a design that counted the limit wrongly would show a second short or long period, or leave overflow set past the strobe. Simultaneous advance and retard are followed by a real request in the same epoch. This separates a correct cancel from one that silently uses up the epoch's step. The sweep test checks that the automatic retard lands on chip 1 of every epoch, that manual requests are ignored while searching, and that raising lock_in stops the stepping after exactly one more epoch.

// File: rtl/ipm_pkg.sv
// Shared types for the incremental code phase stepper.
// Assumes: a step is either none, one clock shorter, or one clock longer.
package ipm_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } ipm_step_e;
endpackage

// File: rtl/ipm_divider.sv
// Programmable chip-period divider. It counts down and reloads on reaching
// zero, with the reload value chosen by the pending step (K-2, K-1 or K).
// tick marks the last cycle of each chip period.
// Assumes RATIO_K >= 4 so every period is at least three cycles long.
module ipm_divider
    import ipm_pkg::*;
#(
    parameter int RATIO_K = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ipm_step_e step_sel,
    output logic      tick
);
    localparam int DIV_W = $clog2(RATIO_K + 1);
    localparam logic [DIV_W-1:0] LOAD_NOM = DIV_W'(RATIO_K - 1);
    localparam logic [DIV_W-1:0] LOAD_ADV = DIV_W'(RATIO_K - 2);
    localparam logic [DIV_W-1:0] LOAD_RET = DIV_W'(RATIO_K);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] load_val;

    // Terminal count of the current chip period.
    assign tick = (cnt_q == '0);

    // Pick the reload value for the next period from the pending step.
    always_comb begin
        case (step_sel)
            STEP_ADV: load_val = LOAD_ADV;
            STEP_RET: load_val = LOAD_RET;
            default:  load_val = LOAD_NOM;
        endcase
    end

    // Count down and reload at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= LOAD_NOM;
        else if (tick)  cnt_q <= load_val;
        else            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/ipm_chip_counter.sv
// Chip position counter within a code epoch. It advances on each divider
// tick, wraps after CODE_LEN chips, and flags the last chip of the epoch.
// Assumes CODE_LEN >= 2.
module ipm_chip_counter #(
    parameter int CODE_LEN = 7,
    localparam int CHIP_W = $clog2(CODE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [CHIP_W-1:0] chip_idx,
    output logic              epoch_stb
);
    localparam logic [CHIP_W-1:0] LAST_IDX = CHIP_W'(CODE_LEN - 1);

    logic [CHIP_W-1:0] idx_q;

    assign chip_idx  = idx_q;
    // The epoch ends on the tick of the final chip.
    assign epoch_stb = tick && (idx_q == LAST_IDX);

    // Step the chip index on each tick and wrap at the epoch end.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (epoch_stb)  idx_q <= '0;
        else if (tick)       idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/ipm_step_arbiter.sv
// Step request arbiter. It merges manual and automatic search requests,
// cancels simultaneous opposite requests, allows one accepted step per
// epoch, holds the accepted step until the divider's next reload, and
// raises a sticky overflow for discarded requests.
// Assumes epoch_stb is coincident with a divider tick.
module ipm_step_arbiter
    import ipm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_req,
    input  logic      ret_req,
    input  logic      sweep_en,
    input  logic      lock_in,
    input  logic      tick,
    input  logic      epoch_stb,
    output ipm_step_e pend_step,
    output logic      overflow
);
    logic      searching;
    logic      man_adv, man_ret, auto_ret;
    logic      want_adv, want_ret, want_any;
    logic      slot_free, accept, reject;
    logic      used_q, ovf_q;
    ipm_step_e pend_q;

    // Decide which request, if any, stands this cycle.
    always_comb begin
        searching = sweep_en && !lock_in;
        man_adv   = adv_req && !searching;
        man_ret   = ret_req && !searching;
        auto_ret  = searching && epoch_stb;
        want_adv  = man_adv && !man_ret;
        want_ret  = (man_ret && !man_adv) || auto_ret;
        want_any  = want_adv || want_ret;
        slot_free = epoch_stb || !used_q;
        accept    = want_any && slot_free;
        reject    = want_any && !slot_free;
    end

    // Track the epoch's step slot and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            used_q <= epoch_stb ? accept : (used_q || accept);
            if (reject)         ovf_q <= 1'b1;
            else if (epoch_stb) ovf_q <= 1'b0;
        end
    end

    // Hold an accepted step until the divider reloads with it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= STEP_NONE;
        else if (accept) pend_q <= want_adv ? STEP_ADV : STEP_RET;
        else if (tick)   pend_q <= STEP_NONE;
    end

    assign pend_step = pend_q;
    assign overflow  = ovf_q;
endmodule

// File: rtl/ipm_phase_stepper.sv
// Incremental code phase stepper top. It generates chip and epoch timing
// from a reference clock at RATIO_K times the chip rate and moves the chip
// phase by one reference cycle per accepted step.
// Assumes 4 <= RATIO_K <= 16 and CODE_LEN >= 2.
module ipm_phase_stepper
    import ipm_pkg::*;
#(
    parameter int RATIO_K  = 4,
    parameter int CODE_LEN = 7,
    localparam int CHIP_W  = $clog2(CODE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_req,
    input  logic              ret_req,
    input  logic              sweep_en,
    input  logic              lock_in,
    output logic              chip_en,
    output logic              epoch_stb,
    output logic [CHIP_W-1:0] chip_idx,
    output logic              overflow
);
    ipm_step_e step_sel;
    logic      tick;

    // Chip-period divider.
    ipm_divider #(.RATIO_K(RATIO_K)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_sel (step_sel),
        .tick     (tick)
    );

    // Chip and epoch position.
    ipm_chip_counter #(.CODE_LEN(CODE_LEN)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .chip_idx  (chip_idx),
        .epoch_stb (epoch_stb)
    );

    // Request arbitration and per-epoch limit.
    ipm_step_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_req   (adv_req),
        .ret_req   (ret_req),
        .sweep_en  (sweep_en),
        .lock_in   (lock_in),
        .tick      (tick),
        .epoch_stb (epoch_stb),
        .pend_step (step_sel),
        .overflow  (overflow)
    );

    assign chip_en = tick;
endmodule

// File: rtl/ipm_phase_stepper_chk.sv
// Property checker for the phase stepper, attached by bind.
// Assumes the same parameters as the bound instance.
module ipm_phase_stepper_chk #(
    parameter int RATIO_K  = 4,
    parameter int CODE_LEN = 7,
    localparam int CHIP_W  = $clog2(CODE_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              epoch_stb,
    input logic [CHIP_W-1:0] chip_idx,
    input logic              overflow
);
    localparam int GAP_W = $clog2(RATIO_K + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(RATIO_K - 2);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(RATIO_K);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the previous chip pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (chip_en) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_chip_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |=> !chip_en);

    // R2 and R3: every period lies in K-1 .. K+1 cycles.
    assert_period_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && seen_q) |-> (gap_q >= GAP_MIN && gap_q <= GAP_MAX));

    assert_idx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_stb |=> (chip_idx == '0));

    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !epoch_stb) |=> (chip_idx == $past(chip_idx) + 1'b1));

    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(chip_idx));

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_stb |=> !overflow);
endmodule

bind ipm_phase_stepper ipm_phase_stepper_chk #(
    .RATIO_K  (RATIO_K),
    .CODE_LEN (CODE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .epoch_stb (epoch_stb),
    .chip_idx  (chip_idx),
    .overflow  (overflow)
);

// File: tb/sim_ipm_phase_stepper.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_ipm_phase_stepper;
    localparam int K = 4;
    localparam int L = 7;
    localparam int CW = $clog2(L);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_req = 1'b0, ret_req = 1'b0;
    logic          sweep_en = 1'b0, lock_in = 1'b0;
    logic          chip_en, epoch_stb, overflow;
    logic [CW-1:0] chip_idx;

    int checks = 0, fails = 0;
    int cyc = 0, last = 0, nlog = 0, nstb = 0;
    int plog [0:4095];
    bit done = 1'b0;

    ipm_phase_stepper #(.RATIO_K(K), .CODE_LEN(L)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .ret_req(ret_req),
        .sweep_en(sweep_en), .lock_in(lock_in), .chip_en(chip_en),
        .epoch_stb(epoch_stb), .chip_idx(chip_idx), .overflow(overflow)
    );

    always #5 clk = ~clk;

    // Log every chip period length (in clocks), sampled on falling edges.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) last = cyc;
        else if (chip_en) begin
            if (nlog < 4096) plog[nlog] = cyc - last;
            last = cyc;
            nlog = nlog + 1;
            if (epoch_stb) nstb = nstb + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(bit a, bit r);
        @(negedge clk); adv_req = a; ret_req = r;
        @(negedge clk); adv_req = 1'b0; ret_req = 1'b0;
    endtask

    task automatic sync_epoch();
        int e = nstb;
        wait (nstb != e);
    endtask

    function automatic int sum_log(int b, int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += plog[b + i];
        return s;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R9 chip_en in reset", int'(chip_en), 0);
        chk("R9 epoch_stb in reset", int'(epoch_stb), 0);
        chk("R9 overflow in reset", int'(overflow), 0);
        chk("R9 chip_idx in reset", int'(chip_idx), 0);
        @(posedge clk); #2 rst_n = 1'b1;
        wait (nlog > 0);
        chk("R9 first period after reset", plog[0], K);
    endtask

    task automatic t_nominal();
        int b;
        sync_epoch();
        b = nlog;
        sync_epoch();
        chk("R4 idx at epoch strobe", int'(chip_idx), L - 1);
        for (int i = 0; i < L; i++) chk("R1 nominal period", plog[b + i], K);
        chk("R4 chips per epoch", nlog - b, L);
        @(negedge clk);
        chk("R4 idx after wrap", int'(chip_idx), 0);
    endtask

    task automatic t_advance();
        int b;
        sync_epoch(); b = nlog;
        pulse(1'b1, 1'b0);
        sync_epoch();
        chk("R2 current period", plog[b], K);
        chk("R2 shortened period", plog[b + 1], K - 1);
        chk("R2 restored period", plog[b + 2], K);
        chk("R2 epoch length", sum_log(b, L), L * K - 1);
    endtask

    task automatic t_retard();
        int b;
        sync_epoch(); b = nlog;
        pulse(1'b0, 1'b1);
        sync_epoch();
        chk("R3 current period", plog[b], K);
        chk("R3 stretched period", plog[b + 1], K + 1);
        chk("R3 restored period", plog[b + 2], K);
    endtask

    task automatic t_overflow();
        int b;
        sync_epoch(); b = nlog;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R5 overflow set", int'(overflow), 1);
        sync_epoch();
        chk("R5 overflow held to strobe", int'(overflow), 1);
        chk("R5 first step honoured", plog[b + 1], K - 1);
        chk("R5 second step ignored", sum_log(b, L), L * K - 1);
        @(negedge clk);
        chk("R5 overflow cleared", int'(overflow), 0);
    endtask

    task automatic t_cancel();
        int b;
        sync_epoch(); b = nlog;
        pulse(1'b1, 1'b1);
        chk("R6 no overflow on cancel", int'(overflow), 0);
        pulse(1'b1, 1'b0);
        sync_epoch();
        chk("R6 cancel gives no step", plog[b], K);
        chk("R6 later request honoured", plog[b + 1], K - 1);
        chk("R6 no overflow after", int'(overflow), 0);
    endtask

    task automatic t_sweep();
        int ba, bb, bc, bd, be;
        sync_epoch(); ba = nlog;
        @(negedge clk); sweep_en = 1'b1;
        pulse(1'b1, 1'b0);
        chk("R7 manual ignored, no overflow", int'(overflow), 0);
        sync_epoch();
        chk("R7 manual ignored while searching", sum_log(ba, L), L * K);
        bb = nlog;
        pulse(1'b1, 1'b0);
        chk("R7 manual ignored mid-search", int'(overflow), 0);
        sync_epoch();
        chk("R7 chip 0 nominal", plog[bb], K);
        chk("R7 auto retard on chip 1", plog[bb + 1], K + 1);
        chk("R7 one step per epoch", sum_log(bb, L), L * K + 1);
        bc = nlog;
        sync_epoch();
        chk("R7 auto retard repeats", plog[bc + 1], K + 1);
        bd = nlog;
        @(negedge clk); lock_in = 1'b1;
        sync_epoch();
        chk("R8 step queued before lock", plog[bd + 1], K + 1);
        be = nlog;
        pulse(1'b1, 1'b0);
        sync_epoch();
        chk("R8 no auto step after lock", plog[be], K);
        chk("R8 manual advance honoured", plog[be + 1], K - 1);
        chk("R8 epoch length after lock", sum_log(be, L), L * K - 1);
        @(negedge clk); sweep_en = 1'b0; lock_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_advance();
        t_retard();
        t_overflow();
        t_cancel();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule